// File: doc/BRIEF.md
# Configurable Serial Transmitter

This block turns parallel words into a serial bit stream on one output line. A word is offered with a valid strobe while the ready flag shows the holding register is empty. At the next transmit clock enable the word moves into a frame shifter and goes out least significant bit first. The frame shape comes from a small set of control inputs: data width (5 to 8 bits), framing (synchronous, or asynchronous with a start bit and one, one-and-a-half or two stop bits), parity on or off with its sense, and bit timing of one or sixteen clock enables per bit.

When a frame ends and no word is waiting, the block reports underrun. In asynchronous framing the line then rests at the marking level. In synchronous framing it sends a fill character from a dedicated input, frame after frame, until real data arrives. A fill character with a full 8-bit width gets computed parity. For narrower widths, the parity bit is the fill character's bit sitting just above its data bits.

Top module: `usart_tx`

## Requirements
- R1: Width code `cfg_wlen` 00, 01, 10, 11 sends 8, 7, 6, 5 data bits, least significant bit first.
- R2: Framing code `cfg_fmt` 00 sends data (and parity) only. Codes 01, 10, 11 send a low start bit first and then high stop bits lasting 1, 1.5 and 2 bit times.
- R3: With `cfg_par_en` high, one parity bit follows the last data bit: the XOR of the data bits when `cfg_even` is 1, its inverse when 0. With `cfg_par_en` low, no parity bit is sent.
- R4: With `cfg_div16` high each bit lasts 16 `tick` enables. With it low, each bit lasts one.
- R5: The 1.5-stop period lasts 24 enables with `cfg_div16` high. With it low it lasts two full bit times.
- R6: `ld_ready` drops in the cycle after a word is accepted. It rises again at the enable on which that word enters the shifter, which is also the first cycle of its frame.
- R7: In asynchronous framing, a frame that ends with no word waiting leaves `txd` high and sets `underrun`. The next data frame clears `underrun` as it starts.
- R8: In synchronous framing, a frame that ends with no word waiting is followed at once by a frame built from `fill_char`, and `underrun` is set.
- R9: A fill frame with 8-bit width carries computed parity. With width N < 8, its parity bit is `fill_char[N]`.
- R10: A word waiting when a frame ends starts its own frame on the same enable, with no idle bit between.
- R11: While reset is asserted and after its release, `txd` is high, `ld_ready` is high and `underrun` is low.
- R12: While `tick` is low, neither the line nor the frame position advances, and a waiting word does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Transmit clock enable |
| cfg_wlen | input | 2 | Data width code |
| cfg_fmt | input | 2 | Framing code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_even | input | 1 | 1 even parity, 0 odd |
| cfg_div16 | input | 1 | 16 enables per bit when high |
| fill_char | input | 8 | Synchronous fill character |
| ld_valid | input | 1 | Word offered |
| ld_data | input | 8 | Offered word |
| ld_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial line |
| underrun | output | 1 | Frame ended with nothing waiting |

## Verification
The hardest situation to reach from the ports is a frame boundary where a second word has to be ready: a fresh word while the shifter is busy, or an empty holding register in synchronous framing. The stimulus creates the first case by loading the next word during slot zero of the running frame, right after ready returns, and then checks the next frame bit by bit starting at the very first cycle after the boundary. It creates the second case by letting one synchronous data frame end with nothing loaded, then checking the fill frames that follow, first with a narrow width where the parity comes from the fill character and then with the full width where it is computed.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;
  localparam int WORD_W  = 8;
  localparam int FRAME_W = WORD_W + 4;
  localparam int SLOT_CW = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    FMT_SYNC   = 2'b00,
    FMT_STOP1  = 2'b01,
    FMT_STOP15 = 2'b10,
    FMT_STOP2  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic [1:0] wlen;
    fmt_e       fmt;
    logic       par_en;
    logic       even;
    logic       div16;
  } cfg_t;
endpackage

// File: rtl/usart_tx_frame.sv
module usart_tx_frame
  import usart_tx_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic               is_fill,
  input  cfg_t               cfg,
  output logic [FRAME_W-1:0] frame,
  output logic [SLOT_CW-1:0] nslots,
  output logic               short_last
);
  localparam int IW = $clog2(WORD_W);

  logic               async_f;
  logic [SLOT_CW-1:0] base, nbits, stops;
  logic [WORD_W-1:0]  dmask, dval;
  logic               par_calc, par_bit;

  assign async_f  = (cfg.fmt != FMT_SYNC);
  assign base     = async_f ? SLOT_CW'(1) : '0;
  assign nbits    = SLOT_CW'(WORD_W) - SLOT_CW'(cfg.wlen);
  assign stops    = !async_f ? '0 : (cfg.fmt == FMT_STOP1) ? SLOT_CW'(1) : SLOT_CW'(2);

  always_comb begin
    for (int i = 0; i < WORD_W; i++) dmask[i] = (i < int'(nbits));
  end

  assign dval     = word & dmask;
  assign par_calc = cfg.even ? ^dval : ~^dval;
  assign par_bit  = (is_fill && nbits != SLOT_CW'(WORD_W)) ? word[nbits[IW-1:0]] : par_calc;

  always_comb begin
    frame = '1;
    if (async_f) frame[0] = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(nbits)) frame[SLOT_CW'(i) + base] = dval[i];
    end
    if (cfg.par_en) frame[nbits + base] = par_bit;
  end

  assign nslots     = base + nbits + SLOT_CW'(cfg.par_en) + stops;
  assign short_last = cfg.div16 && (cfg.fmt == FMT_STOP15);
endmodule

// File: rtl/usart_tx_timer.sv
module usart_tx_timer #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  input  logic div16,
  input  logic short_slot,
  output logic slot_end
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d, limit;

  assign limit    = !div16 ? '0 : short_slot ? CW'(HALF - 1) : CW'(DIV - 1);
  assign slot_end = run && tick && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)          cnt_d = '0;
    else if (run && tick) cnt_d = slot_end ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
  // R4
  x1_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !div16 && !restart) |=> (cnt_q == '0));
endmodule

// File: rtl/usart_tx_hold.sv
module usart_tx_hold
  import usart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] data
);
  logic              full_d;
  logic [WORD_W-1:0] data_d;

  always_comb begin
    full_d = full;
    data_d = data;
    if (take) full_d = 1'b0;
    else if (ld_valid && !full) begin
      full_d = 1'b1;
      data_d = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end

  // R6
  take_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  // R6
  take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !full);
endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_tx_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cfg_wlen,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_par_en,
  input  logic              cfg_even,
  input  logic              cfg_div16,
  input  logic [WORD_W-1:0] fill_char,
  input  logic              ld_valid,
  input  logic [WORD_W-1:0] ld_data,
  output logic              ld_ready,
  output logic              txd,
  output logic              underrun
);
  cfg_t cfg;
  assign cfg = '{wlen: cfg_wlen, fmt: fmt_e'(cfg_fmt), par_en: cfg_par_en,
                 even: cfg_even, div16: cfg_div16};

  logic               hold_full, take;
  logic [WORD_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame;
  logic [SLOT_CW-1:0] nslots;
  logic               short_last, slot_end;
  logic               boundary, start_data, start_fill, start;

  logic               active_q, active_d, under_q, under_d;
  logic               div_q, div_d, short_q, short_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [SLOT_CW-1:0] left_q, left_d;

  usart_tx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .take(take), .full(hold_full), .data(hold_data)
  );

  usart_tx_frame u_frame (
    .word(hold_full ? hold_data : fill_char), .is_fill(!hold_full), .cfg(cfg),
    .frame(frame), .nslots(nslots), .short_last(short_last)
  );

  usart_tx_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(active_q), .restart(start),
    .div16(div_q), .short_slot(short_q && left_q == SLOT_CW'(1)), .slot_end(slot_end)
  );

  assign boundary   = tick && (!active_q || (slot_end && left_q == SLOT_CW'(1)));
  assign start_data = boundary && hold_full;
  assign start_fill = boundary && !hold_full && active_q && (cfg.fmt == FMT_SYNC);
  assign start      = start_data || start_fill;
  assign take       = start_data;

  always_comb begin
    active_d = active_q;
    under_d  = under_q;
    div_d    = div_q;
    short_d  = short_q;
    shreg_d  = shreg_q;
    left_d   = left_q;
    if (start) begin
      active_d = 1'b1;
      under_d  = start_fill;
      div_d    = cfg.div16;
      short_d  = short_last;
      shreg_d  = frame;
      left_d   = nslots;
    end else if (boundary && active_q) begin
      active_d = 1'b0;
      under_d  = 1'b1;
    end else if (slot_end) begin
      shreg_d  = {1'b1, shreg_q[FRAME_W-1:1]};
      left_d   = left_q - SLOT_CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      under_q  <= 1'b0;
      div_q    <= 1'b0;
      short_q  <= 1'b0;
      shreg_q  <= '1;
      left_q   <= '0;
    end else begin
      active_q <= active_d;
      under_q  <= under_d;
      div_q    <= div_d;
      short_q  <= short_d;
      shreg_q  <= shreg_d;
      left_q   <= left_d;
    end
  end

  assign txd      = active_q ? shreg_q[0] : 1'b1;
  assign ld_ready = !hold_full;
  assign underrun = under_q;

  // R2
  async_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg.fmt != FMT_SYNC) |=> !txd);
  // R7
  mark_on_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && active_q && !hold_full && cfg.fmt != FMT_SYNC) |=> (txd && underrun));
  // R8
  sync_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && active_q && !hold_full && cfg.fmt == FMT_SYNC) |=> (active_q && underrun));
  // R10
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && active_q && hold_full) |=> (active_q && !underrun));
  // R12
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(txd) && $stable(underrun)));
endmodule

// File: tb/usart_tx_bench.sv
module usart_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] cfg_wlen = 2'b00, cfg_fmt = 2'b01;
  logic       cfg_par_en = 1'b0, cfg_even = 1'b0, cfg_div16 = 1'b0;
  logic [7:0] fill_char = 8'h00, ld_data = 8'h00;
  logic       ld_valid = 1'b0;
  logic       ld_ready, txd, underrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usart_tx u_usart_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wlen(cfg_wlen), .cfg_fmt(cfg_fmt),
    .cfg_par_en(cfg_par_en), .cfg_even(cfg_even), .cfg_div16(cfg_div16),
    .fill_char(fill_char), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_ready(ld_ready), .txd(txd), .underrun(underrun)
  );

  typedef struct packed {
    logic [7:0] data;
    logic [1:0] wl;
    logic [1:0] fmt;
    logic       pe;
    logic       ev;
    logic       dv;
    logic [3:0] slots;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{8'hA5, 2'b00, 2'b01, 1'b1, 1'b1, 1'b0, 4'd11},
    '{8'h3C, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 4'd11},
    '{8'h1F, 2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 4'd8},
    '{8'h55, 2'b10, 2'b01, 1'b1, 1'b1, 1'b1, 4'd9},
    '{8'h81, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 4'd11},
    '{8'hFF, 2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 4'd12}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void exp_frame(input logic [7:0] w, input bit fill,
                                    output logic [11:0] bits);
    int  nb = 8 - int'(cfg_wlen);
    int  n  = 0;
    logic p = !cfg_even;
    bits = '1;
    if (cfg_fmt != 2'b00) begin bits[n] = 1'b0; n++; end
    for (int i = 0; i < nb; i++) begin bits[n] = w[i]; p ^= w[i]; n++; end
    if (cfg_par_en) bits[n] = (fill && nb < 8) ? w[nb] : p;
  endfunction

  // Entered at the first negedge of slot 0; leaves at the first negedge after the frame.
  task automatic check_frame(input logic [7:0] w, input bit fill, input int n,
                             input bit nxt_en, input logic [7:0] nxt, input string tag);
    logic [11:0] bits;
    exp_frame(w, fill, bits);
    for (int k = 0; k < n; k++) begin
      int len = !cfg_div16 ? 1 : (cfg_fmt == 2'b10 && k == n - 1) ? 8 : 16;
      chk(tag, 32'(txd), 32'(bits[k]));
      if (k == 0 && nxt_en) begin ld_data = nxt; ld_valid = 1'b1; end
      @(negedge clk);
      ld_valid = 1'b0;
      if (len > 1) begin
        repeat (len - 2) @(negedge clk);
        chk({tag, " R4 R5 slot end"}, 32'(txd), 32'(bits[k]));
        @(negedge clk);
      end
    end
  endtask

  // Loads one word while idle; leaves at the first negedge of the frame.
  task automatic load_word(input logic [7:0] w);
    ld_data = w;
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R6 ready low after load", 32'(ld_ready), 32'd0);
    @(negedge clk);
    chk("R6 ready high at transfer", 32'(ld_ready), 32'd1);
    chk("R7 underrun cleared by data", 32'(underrun), 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 txd in reset", 32'(txd), 32'd1);
    chk("R11 ready in reset", 32'(ld_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 txd after reset", 32'(txd), 32'd1);
    chk("R11 underrun after reset", 32'(underrun), 32'd0);
  endtask

  initial begin
    do_reset();

    // Table: R1 R2 R3 R4 R5 R7
    foreach (VECS[v]) begin
      cfg_wlen = VECS[v].wl; cfg_fmt = VECS[v].fmt; cfg_par_en = VECS[v].pe;
      cfg_even = VECS[v].ev; cfg_div16 = VECS[v].dv;
      load_word(VECS[v].data);
      check_frame(VECS[v].data, 1'b0, int'(VECS[v].slots), 1'b0, 8'h00, "R1 R2 R3 bit");
      chk("R7 line marks", 32'(txd), 32'd1);
      chk("R7 underrun set", 32'(underrun), 32'd1);
    end

    // R10 back-to-back words
    cfg_wlen = 2'b00; cfg_fmt = 2'b01; cfg_par_en = 1'b0; cfg_div16 = 1'b0;
    load_word(8'h5A);
    check_frame(8'h5A, 1'b0, 10, 1'b1, 8'hC3, "R10 first");
    chk("R10 no underrun between", 32'(underrun), 32'd0);
    chk("R10 ready after second transfer", 32'(ld_ready), 32'd1);
    check_frame(8'hC3, 1'b0, 10, 1'b0, 8'h00, "R10 second");
    chk("R7 idle after pair", 32'(txd), 32'd1);

    // R12 no progress without enables
    tick = 1'b0;
    ld_data = 8'h33; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    for (int c = 0; c < 5; c++) begin
      chk("R12 line held", 32'(txd), 32'd1);
      chk("R12 word waits", 32'(ld_ready), 32'd0);
      @(negedge clk);
    end
    tick = 1'b1;
    @(negedge clk);
    check_frame(8'h33, 1'b0, 10, 1'b0, 8'h00, "R12 after enable");

    // R8 R9 synchronous fill, narrow width
    do_reset();
    cfg_wlen = 2'b01; cfg_fmt = 2'b00; cfg_par_en = 1'b1; cfg_even = 1'b1;
    cfg_div16 = 1'b0; fill_char = 8'hAB;
    load_word(8'h12);
    check_frame(8'h12, 1'b0, 8, 1'b0, 8'h00, "R2 R3 sync data");
    chk("R8 underrun on fill", 32'(underrun), 32'd1);
    check_frame(8'hAB, 1'b1, 8, 1'b0, 8'h00, "R8 R9 fill narrow");
    check_frame(8'hAB, 1'b1, 8, 1'b0, 8'h00, "R8 fill repeats");

    // R9 synchronous fill, full width with computed parity
    do_reset();
    cfg_wlen = 2'b00; fill_char = 8'h07;
    load_word(8'h00);
    check_frame(8'h00, 1'b0, 9, 1'b0, 8'h00, "R3 sync data");
    check_frame(8'h07, 1'b1, 9, 1'b0, 8'h00, "R9 fill full");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule